// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

The arbiter watches a wide set of interrupt request lines and picks the single request that the processor should take next. Each source has its own enable bit and its own group bit, which places it in either the high or the low group. The choice is made in two steps. First, any eligible high-group request beats every eligible low-group request. Second, inside the winning group, the smallest vector number wins. The winner's vector number and group are registered and presented together with a valid flag.

The block also tracks which level is being serviced, which allows one level of nesting. A low-group handler can be preempted by a high-group request. A high-group handler cannot be preempted by anything. The processor's acknowledge starts service and a return strobe ends it.

Vector 0 is not fed from a line. It is a software interrupt, latched by a one-cycle set pulse. Vector slots declared unassigned by a parameter mask are never chosen. With vectored mode off, the block still reports whether each group has anything pending, but it offers no vector.

Top module: `vint_arb`

## Requirements
- R1: A source counts as eligible only when its request, its own enable bit and the enable of its group (`grp_hi_en` when its `irq_hi` bit is 1, `grp_lo_en` when it is 0) are all set.
- R2: When an allowed high-group source is eligible, `vec_valid` never presents a low-group source (`vec_hi` = 1 means high group).
- R3: Within the presented group, the eligible source with the smallest vector number is the one presented.
- R4: `vec_valid`, `vec_num`, `vec_hi`, `pend_hi` and `pend_lo` are registered. They reflect the inputs sampled at the previous rising clock edge. Synchronous active-high reset clears all of them and clears the service state.
- R5: With `vec_mode_en` low, the next cycle shows `vec_valid` = 0 and `vec_num` = 0. `pend_hi` and `pend_lo` still report whether any high-group or low-group source is eligible.
- R6: An `ack` while `vec_valid` is 1 latches the presented vector and group and clears `vec_valid` on the next cycle. The service state `svc_state` (0 idle, 1 low, 2 high, 3 high over low) moves from idle to 1 or 2 depending on the group, and from low to 3.
- R7: While `svc_state` is 1, only high-group sources may be presented.
- R8: While `svc_state` is 2 or 3, nothing is presented until a return.
- R9: A `reti` moves state 3 to 1, restoring `svc_vec` to the low handler's vector, and moves states 2 and 1 to 0. `svc_vec` shows the vector of the handler in service, or 0 when idle.
- R10: A one-cycle `sw_set` pulse makes vector 0 pending until vector 0 is acknowledged. Its group comes from `irq_hi[0]` and its enable from `irq_en[0]`.
- R11: Sources flagged in the `RSVD_MASK` parameter (default: vector 63 only) are never eligible.
- R12: An `ack` while `vec_valid` is 0 leaves the service state unchanged. When `ack` is taken in the same cycle as `reti`, the `reti` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode_en | input | 1 | Vectored mode enable |
| grp_hi_en | input | 1 | Global enable for the high group |
| grp_lo_en | input | 1 | Global enable for the low group |
| sw_set | input | 1 | Pulse that raises the software interrupt (vector 0) |
| irq_req | input | NUM_SRC-1 | Request lines for vectors 1..NUM_SRC-1 (bit index = vector) |
| irq_en | input | NUM_SRC | Per-source enable |
| irq_hi | input | NUM_SRC | Per-source group select, 1 = high |
| ack | input | 1 | Processor accepts the presented vector |
| reti | input | 1 | Return from the current handler |
| vec_valid | output | 1 | A vector is being offered |
| vec_num | output | VEC_W | Offered vector number |
| vec_hi | output | 1 | Offered vector belongs to the high group |
| pend_hi | output | 1 | Some high-group source is eligible |
| pend_lo | output | 1 | Some low-group source is eligible |
| svc_state | output | 2 | Service level: 0 idle, 1 low, 2 high, 3 high over low |
| svc_vec | output | VEC_W | Vector of the handler in service |

## Verification
The hardest state to reach is a high-group handler nested on top of a low-group one, with further requests of both groups held pending. The bench gets there with a directed sequence:
- acknowledge a low request;
- raise a lower-numbered low request and check that it is held back;
- raise a high request and acknowledge it;
- raise another high request and check that it is blocked.

Two returns then unwind the nest. In between, the bench checks that the blocked high request appears exactly one cycle after the return to low service, and that `svc_vec` falls back to the first vector.

// File: rtl/vint_pkg.sv
package vint_pkg;

    localparam int unsigned SRC_COUNT_DEF = 80;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_LO   = 2'd1,
        SVC_HI   = 2'd2,
        SVC_NEST = 2'd3
    } svc_e;

    typedef struct packed {
        logic hi_any;
        logic lo_any;
    } grp_pend_t;

    function automatic logic lo_allowed(input svc_e s);
        return s == SVC_IDLE;
    endfunction

    function automatic logic hi_allowed(input svc_e s);
        return (s == SVC_IDLE) || (s == SVC_LO);
    endfunction

endpackage

// File: rtl/vint_qualify.sv
module vint_qualify #(
    parameter int unsigned        NUM_SRC   = 80,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = '0
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] hi,
    input  logic               grp_hi_en,
    input  logic               grp_lo_en,
    output logic [NUM_SRC-1:0] elig_hi,
    output logic [NUM_SRC-1:0] elig_lo
);
    logic [NUM_SRC-1:0] live;

    assign live = req & en & ~RSVD_MASK;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign elig_hi[i] = live[i] &  hi[i] & grp_hi_en;
        assign elig_lo[i] = live[i] & ~hi[i] & grp_lo_en;
    end
endmodule

// File: rtl/vint_pick.sv
module vint_pick #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned VEC_W   = 7
) (
    input  logic [NUM_SRC-1:0] mask,
    output logic               found,
    output logic [VEC_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/vint_nest.sv
module vint_nest
    import vint_pkg::*;
#(
    parameter int unsigned VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             take_hi,
    input  logic [VEC_W-1:0] take_vec,
    input  logic             ret,
    output svc_e             state,
    output logic [VEC_W-1:0] cur_vec
);
    svc_e             state_q, state_d;
    logic [VEC_W-1:0] lo_vec_q, hi_vec_q;

    always_comb begin
        state_d = state_q;
        if (take) begin
            unique case (state_q)
                SVC_IDLE: state_d = take_hi ? SVC_HI : SVC_LO;
                SVC_LO:   state_d = SVC_NEST;
                default:  state_d = state_q;
            endcase
        end else if (ret) begin
            unique case (state_q)
                SVC_NEST: state_d = SVC_LO;
                SVC_HI:   state_d = SVC_IDLE;
                SVC_LO:   state_d = SVC_IDLE;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SVC_IDLE;
            lo_vec_q <= '0;
            hi_vec_q <= '0;
        end else begin
            state_q <= state_d;
            if (take && take_hi)  hi_vec_q <= take_vec;
            if (take && !take_hi) lo_vec_q <= take_vec;
        end
    end

    assign state = state_q;

    always_comb begin
        unique case (state_q)
            SVC_LO:           cur_vec = lo_vec_q;
            SVC_HI, SVC_NEST: cur_vec = hi_vec_q;
            default:          cur_vec = '0;
        endcase
    end
endmodule

// File: rtl/vint_arb.sv
module vint_arb
    import vint_pkg::*;
#(
    parameter int unsigned        NUM_SRC   = SRC_COUNT_DEF,
    parameter int unsigned        VEC_W     = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0] RSVD_MASK = NUM_SRC'(64'h8000_0000_0000_0000)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vec_mode_en,
    input  logic               grp_hi_en,
    input  logic               grp_lo_en,
    input  logic               sw_set,
    input  logic [NUM_SRC-1:1] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] irq_hi,
    input  logic               ack,
    input  logic               reti,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_num,
    output logic               vec_hi,
    output logic               pend_hi,
    output logic               pend_lo,
    output logic [1:0]         svc_state,
    output logic [VEC_W-1:0]   svc_vec
);
    logic               sw_q;
    logic [NUM_SRC-1:0] req_all, elig_hi, elig_lo;
    logic               hit_hi, hit_lo;
    logic [VEC_W-1:0]   vec_hi_c, vec_lo_c;
    svc_e               state;
    grp_pend_t          pend_q;
    logic               vld_q, grp_q;
    logic [VEC_W-1:0]   num_q;
    logic               take, ret, use_hi, use_lo, offer;

    assign req_all = {irq_req, sw_q};

    vint_qualify #(.NUM_SRC(NUM_SRC), .RSVD_MASK(RSVD_MASK)) u_qual (
        .req(req_all), .en(irq_en), .hi(irq_hi),
        .grp_hi_en(grp_hi_en), .grp_lo_en(grp_lo_en),
        .elig_hi(elig_hi), .elig_lo(elig_lo)
    );

    vint_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick_hi (
        .mask(elig_hi), .found(hit_hi), .idx(vec_hi_c)
    );

    vint_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick_lo (
        .mask(elig_lo), .found(hit_lo), .idx(vec_lo_c)
    );

    assign take   = ack & vld_q;
    assign ret    = reti & ~take;
    assign use_hi = hit_hi & hi_allowed(state);
    assign use_lo = ~use_hi & hit_lo & lo_allowed(state);
    assign offer  = vec_mode_en & (use_hi | use_lo) & ~take;

    vint_nest #(.VEC_W(VEC_W)) u_nest (
        .clk(clk), .rst(rst),
        .take(take), .take_hi(grp_q), .take_vec(num_q),
        .ret(ret), .state(state), .cur_vec(svc_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q   <= 1'b0;
            pend_q <= '0;
            vld_q  <= 1'b0;
            grp_q  <= 1'b0;
            num_q  <= '0;
        end else begin
            sw_q          <= sw_set | (sw_q & ~(take && num_q == '0));
            pend_q.hi_any <= hit_hi;
            pend_q.lo_any <= hit_lo;
            vld_q         <= offer;
            grp_q         <= offer & use_hi;
            num_q         <= offer ? (use_hi ? vec_hi_c : vec_lo_c) : '0;
        end
    end

    assign vec_valid = vld_q;
    assign vec_num   = num_q;
    assign vec_hi    = grp_q;
    assign pend_hi   = pend_q.hi_any;
    assign pend_lo   = pend_q.lo_any;
    assign svc_state = state;
endmodule

// File: rtl/vint_arb_chk.sv
module vint_arb_chk #(
    parameter int unsigned        NUM_SRC   = 80,
    parameter int unsigned        VEC_W     = 7,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             vec_mode_en,
    input logic             ack,
    input logic             reti,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_num,
    input logic             vec_hi,
    input logic             pend_hi,
    input logic [1:0]       svc_state
);
    logic [(2**VEC_W)-1:0] rsvd_ext;
    assign rsvd_ext = (2**VEC_W)'(RSVD_MASK);

    assert_mode_off_R5: assert property (@(posedge clk) disable iff (rst)
        !vec_mode_en |=> (!vec_valid && vec_num == '0));

    assert_hi_first_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_hi) |-> !pend_hi);

    assert_rsvd_never_R11: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !rsvd_ext[vec_num]);

    assert_lo_svc_hi_only_R7: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && svc_state == 2'd1) |-> vec_hi);

    assert_hi_svc_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        svc_state[1] |-> !vec_valid);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && vec_valid) |=> !vec_valid);

    assert_ack_enter_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && vec_valid && svc_state == 2'd0) |=>
            (svc_state == ($past(vec_hi) ? 2'd2 : 2'd1)));

    assert_reti_unnest_R9: assert property (@(posedge clk) disable iff (rst)
        (reti && !(ack && vec_valid) && svc_state == 2'd3) |=> svc_state == 2'd1);

    assert_stray_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (ack && !vec_valid && !reti) |=> $stable(svc_state));
endmodule

bind vint_arb vint_arb_chk #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .RSVD_MASK(RSVD_MASK)
) u_chk (
    .clk(clk), .rst(rst), .vec_mode_en(vec_mode_en), .ack(ack), .reti(reti),
    .vec_valid(vec_valid), .vec_num(vec_num), .vec_hi(vec_hi),
    .pend_hi(pend_hi), .svc_state(svc_state)
);

// File: tb/vint_arb_test.sv
`timescale 1ns/1ps
module vint_arb_test;
    localparam int N = 80;
    localparam int W = 7;

    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] en;
        logic [N-1:0] hi;
        logic         ghi, glo, mode;
        logic         e_vld;
        logic [W-1:0] e_num;
        logic         e_hi, e_ahi, e_alo;
    } row_t;

    function automatic logic [N-1:0] B(input int i);
        return N'(1) << i;
    endfunction

    localparam logic [N-1:0] ALL = '1;

    // R1, R2, R3, R5, R11 are covered by these rows
    localparam row_t ROWS [9] = '{
        '{B(5)|B(9),        ALL,        '0,           1'b1,1'b1,1'b1, 1'b1, 7'd5,  1'b0,1'b0,1'b1}, // R3 low group
        '{B(5)|B(9),        ALL,        B(9),         1'b1,1'b1,1'b1, 1'b1, 7'd9,  1'b1,1'b1,1'b1}, // R2
        '{B(12)|B(30)|B(70),ALL,        B(30)|B(70),  1'b1,1'b1,1'b1, 1'b1, 7'd30, 1'b1,1'b1,1'b1}, // R3 high group
        '{B(5)|B(9),        ~B(5),      '0,           1'b1,1'b1,1'b1, 1'b1, 7'd9,  1'b0,1'b0,1'b1}, // R1 enable bit
        '{B(5)|B(9),        ALL,        B(5),         1'b0,1'b1,1'b1, 1'b1, 7'd9,  1'b0,1'b0,1'b1}, // R1 group enable
        '{B(63),            ALL,        '0,           1'b1,1'b1,1'b1, 1'b0, 7'd0,  1'b0,1'b0,1'b0}, // R11
        '{B(63)|B(64),      ALL,        '0,           1'b1,1'b1,1'b1, 1'b1, 7'd64, 1'b0,1'b0,1'b1}, // R11
        '{B(5),             ALL,        B(5),         1'b1,1'b1,1'b0, 1'b0, 7'd0,  1'b0,1'b1,1'b0}, // R5
        '{'0,               ALL,        '0,           1'b1,1'b1,1'b1, 1'b0, 7'd0,  1'b0,1'b0,1'b0}  // idle
    };

    logic         clk = 1'b0, rst = 1'b1;
    logic         vec_mode_en = 1'b0, grp_hi_en = 1'b0, grp_lo_en = 1'b0, sw_set = 1'b0;
    logic [N-1:0] req = '0, en = '0, hi = '0;
    logic         ack = 1'b0, reti = 1'b0;
    logic         vec_valid, vec_hi, pend_hi, pend_lo;
    logic [W-1:0] vec_num, svc_vec;
    logic [1:0]   svc_state;
    int           n_chk = 0, n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    vint_arb uut (
        .clk(clk), .rst(rst), .vec_mode_en(vec_mode_en), .grp_hi_en(grp_hi_en),
        .grp_lo_en(grp_lo_en), .sw_set(sw_set), .irq_req(req[N-1:1]), .irq_en(en),
        .irq_hi(hi), .ack(ack), .reti(reti), .vec_valid(vec_valid), .vec_num(vec_num),
        .vec_hi(vec_hi), .pend_hi(pend_hi), .pend_lo(pend_lo), .svc_state(svc_state),
        .svc_vec(svc_vec)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic offer(input string tag, input logic v, input int num, input logic h);
        chk({tag, " valid"}, 32'(vec_valid), 32'(v));
        chk({tag, " num"},   32'(vec_num),   32'(num));
        chk({tag, " group"}, 32'(vec_hi),    32'(h));
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk); step(); step();
        rst = 1'b0;
        // R4 reset state
        chk("R4 reset valid", 32'(vec_valid), 0);
        chk("R4 reset state", 32'(svc_state), 0);
        chk("R4 reset pend",  32'({pend_hi, pend_lo}), 0);

        // Table walk, service state stays idle throughout
        for (int r = 0; r < 9; r++) begin
            req = ROWS[r].req; en = ROWS[r].en; hi = ROWS[r].hi;
            grp_hi_en = ROWS[r].ghi; grp_lo_en = ROWS[r].glo; vec_mode_en = ROWS[r].mode;
            step(); // R4: registered one edge later
            offer($sformatf("R1/R2/R3/R5/R11 row %0d", r), ROWS[r].e_vld, int'(ROWS[r].e_num), ROWS[r].e_hi);
            chk($sformatf("R5 row %0d pend", r), 32'({pend_hi, pend_lo}),
                32'({ROWS[r].e_ahi, ROWS[r].e_alo}));
        end

        en = ALL; grp_hi_en = 1'b1; grp_lo_en = 1'b1; vec_mode_en = 1'b1; req = '0; hi = '0;
        step();

        // R12 stray acknowledge
        pulse_ack();
        chk("R12 stray ack", 32'(svc_state), 0);

        // Nesting sequence
        req = B(20); step();
        offer("R6 low offer", 1'b1, 20, 1'b0);
        pulse_ack();
        chk("R6 enter low", 32'(svc_state), 1);
        chk("R6 valid drop", 32'(vec_valid), 0);
        chk("R9 svc_vec low", 32'(svc_vec), 20);
        req = B(10); step();
        chk("R7 low blocked", 32'(vec_valid), 0);
        req = B(10) | B(40); hi = B(40); step();
        offer("R7 high preempts", 1'b1, 40, 1'b1);
        pulse_ack();
        chk("R6 nest", 32'(svc_state), 3);
        chk("R9 svc_vec high", 32'(svc_vec), 40);
        req = B(10) | B(35); hi = B(35); step(); step();
        chk("R8 high blocked", 32'(vec_valid), 0);
        pulse_reti();
        chk("R9 unnest", 32'(svc_state), 1);
        chk("R9 svc_vec restored", 32'(svc_vec), 20);
        chk("R8 no offer on unnest edge", 32'(vec_valid), 0);
        step();
        offer("R7 high after unnest", 1'b1, 35, 1'b1);
        req = '0; step();
        pulse_reti();
        chk("R9 low to idle", 32'(svc_state), 0);

        // R12 ack and reti together: reti ignored
        req = B(3); hi = '0; step();
        reti = 1'b1; pulse_ack(); reti = 1'b0;
        chk("R12 ack beats reti", 32'(svc_state), 1);
        req = '0; step(); pulse_reti();

        // R10 software interrupt, high group
        hi = B(0); sw_set = 1'b1; step(); sw_set = 1'b0;
        chk("R10 not yet offered", 32'(vec_valid), 0);
        step();
        offer("R10 sw offer", 1'b1, 0, 1'b1);
        step();
        chk("R10 sticky", 32'(vec_valid), 1);
        pulse_ack();
        chk("R6 idle to high", 32'(svc_state), 2);
        pulse_reti();
        chk("R9 high to idle", 32'(svc_state), 0);
        step();
        chk("R10 cleared by ack", 32'(vec_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule